// File: doc/BRIEF.md
# Privileged SPR Access Control Unit

This block owns a small group of special-purpose registers: a one-bit run-control flag, a 25-bit data-stream control register, and two facility-enable registers. The ordinary enable register holds three bits and the hypervisor enable register holds four. Each move-from-SPR or move-to-SPR request arrives with an SPR number, a privilege mode and a mask of the facilities the instruction uses. The block answers in the same cycle. It returns read data and a hit flag, or raises one of three faults: facility unavailable, hypervisor facility unavailable, or illegal instruction. A permitted write lands at the next clock edge.

The run-control flag is asymmetric. It is written only at SPR 152, and only by privileged code. It is read only at SPR 136, by any code. On a privileged read the flag appears in bit 15 as well as in bit 0. The data-stream register has two numbers: SPR 3, which user code may use when both enable registers allow it, and SPR 17, which only privileged code may use. A debug port reads and writes the two enable registers. The run flag also drives an output pin.

Top module: `spr_guard`

## Requirements
- R1: After reset, the run flag, the data-stream register and both enable registers are zero, and `run_o` is 0.
- R2: A write at SPR 152 in supervisor or hypervisor mode sets the run flag to `req_wdata_i[0]`. `run_o` shows the new value from the next cycle on.
- R3: A read at SPR 136 returns the run flag in bit 0 in user mode. In supervisor or hypervisor mode it returns the flag in bits 0 and 15. All other bits are 0.
- R4: The following are illegal in user mode: a read at SPR 152, a write at SPR 152 and a write at SPR 136. In privileged modes the first and last are no-ops that return zero read data and raise no fault.
- R5: The data-stream register keeps `req_wdata_i[24:0]` on a permitted write at SPR 3 or 17. A read returns it zero-extended.
- R6: In user mode, SPR 3 raises hypervisor facility unavailable when hypervisor enable bit 2 is 0. Otherwise it raises facility unavailable when ordinary enable bit 2 is 0. Any user access at SPR 17 is illegal.
- R7: In supervisor mode (`req_mode_i`=1), SPR 3 and SPR 17 need only hypervisor enable bit 2. The ordinary enable register has no effect there.
- R8: In hypervisor mode (`req_mode_i`=2 or 3), no enable bit gates any access.
- R9: The facility mask in `req_uses_i` is checked as follows. Bit 0 (prefixed) is gated by enable bit 0 and bit 1 (target-address register) by enable bit 1; in user mode both registers apply, in supervisor mode only the hypervisor register. Bit 2 (floating point) is gated outside hypervisor mode by hypervisor enable bit 3 and raises hypervisor facility unavailable.
- R10: A debug write at address 0x2e loads the ordinary enable register from `dbg_wdata_i[2:0]`. A write at 0x2f loads the hypervisor enable register from `dbg_wdata_i[3:0]`. Debug reads return those registers zero-extended. Other addresses read 0 and store nothing.
- R11: At most one fault is raised, in the order hypervisor facility unavailable, then facility unavailable, then illegal. A faulted request reads zero and changes no register.
- R12: An SPR number outside {3, 17, 136, 152} gives `hit_o`=0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | SPR request valid |
| req_write_i | input | 1 | 1 = move to SPR, 0 = move from SPR |
| req_spr_i | input | 10 | SPR number |
| req_mode_i | input | 2 | 0 user, 1 supervisor, 2 or 3 hypervisor |
| req_uses_i | input | 3 | Facilities used: bit0 prefixed, bit1 target-address reg, bit2 floating point |
| req_wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data, zero unless a permitted read |
| hit_o | output | 1 | SPR number belongs to this block |
| fac_unavail_o | output | 1 | Facility unavailable fault |
| hfac_unavail_o | output | 1 | Hypervisor facility unavailable fault |
| illegal_o | output | 1 | Illegal instruction fault |
| dbg_valid_i | input | 1 | Debug access valid |
| dbg_write_i | input | 1 | Debug write |
| dbg_addr_i | input | 7 | Debug register address |
| dbg_wdata_i | input | 64 | Debug write data |
| dbg_rdata_o | output | 64 | Debug read data |
| run_o | output | 1 | Current run flag |

## Verification
Each SPR number is tried in all three privilege modes, for both reads and writes. This separates the user-visible run read from the mirrored privileged read, and separates legal no-ops from illegal accesses. The enable registers are changed one bit at a time: clearing only the hypervisor data-stream bit, then only the ordinary one, shows which mode each register governs and which fault wins. Probes on unowned numbers that set a single bit of the facility mask tie each enable bit to its fault. Reads made after blocked writes show that a faulted request leaves state untouched.

// File: rtl/spr_guard_pkg.sv
package spr_guard_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_HV   = 2'd2,
    MODE_HV2  = 2'd3
  } priv_mode_e;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_RUN  = 2'd1,
    RSEL_DSCR = 2'd2
  } rsel_e;

  // enable bit positions, shared by both enable registers
  localparam int EN_PFX  = 0;
  localparam int EN_TAR  = 1;
  localparam int EN_DSCR = 2;
  localparam int EN_FP   = 3;
  localparam int FEN_W   = 3;
  localparam int HEN_W   = 4;

  typedef struct packed {
    logic hfac;
    logic fac;
    logic ill;
  } fault_t;
endpackage

// File: rtl/spr_guard_decode.sv
module spr_guard_decode
  import spr_guard_pkg::*;
#(
  parameter int SPR_W      = 10,
  parameter int SPR_DS_USR = 3,
  parameter int SPR_DS_PRV = 17,
  parameter int SPR_RUN_RD = 136,
  parameter int SPR_RUN_WR = 152
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [SPR_W-1:0] spr_i,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       uses_i,
  input  logic [FEN_W-1:0] fen_i,
  input  logic [HEN_W-1:0] hen_i,
  output logic             hit_o,
  output rsel_e            rsel_o,
  output logic             run_we_o,
  output logic             dscr_we_o,
  output fault_t           fault_o
);
  logic is_user, is_hv, at_du, at_dp, at_rr, at_rw, own_ds;
  logic hneed, fneed, ill_c, ok;

  always_comb begin
    is_user = (mode_i == MODE_USER);
    is_hv   = mode_i[1];
    at_du   = (spr_i == SPR_W'(SPR_DS_USR));
    at_dp   = (spr_i == SPR_W'(SPR_DS_PRV));
    at_rr   = (spr_i == SPR_W'(SPR_RUN_RD));
    at_rw   = (spr_i == SPR_W'(SPR_RUN_WR));
    own_ds  = at_du | at_dp;
    hit_o   = valid_i & (own_ds | at_rr | at_rw);

    ill_c = is_user & (at_dp | at_rw | (at_rr & write_i));

    hneed = 1'b0;
    fneed = 1'b0;
    if (!is_hv) begin
      if (own_ds && !(is_user && at_dp) && !hen_i[EN_DSCR]) hneed = 1'b1;
      if (uses_i[0] && !hen_i[EN_PFX]) hneed = 1'b1;
      if (uses_i[1] && !hen_i[EN_TAR]) hneed = 1'b1;
      if (uses_i[2] && !hen_i[EN_FP])  hneed = 1'b1;
    end
    if (is_user) begin
      if (at_du && !fen_i[EN_DSCR])    fneed = 1'b1;
      if (uses_i[0] && !fen_i[EN_PFX]) fneed = 1'b1;
      if (uses_i[1] && !fen_i[EN_TAR]) fneed = 1'b1;
    end

    fault_o.hfac = valid_i & hneed;
    fault_o.fac  = valid_i & fneed & ~hneed;
    fault_o.ill  = valid_i & ill_c & ~hneed & ~fneed;
    ok           = valid_i & ~hneed & ~fneed & ~ill_c;

    run_we_o  = ok & write_i & at_rw;
    dscr_we_o = ok & write_i & own_ds;
    rsel_o    = RSEL_NONE;
    if (ok && !write_i) begin
      if (at_rr)       rsel_o = RSEL_RUN;
      else if (own_ds) rsel_o = RSEL_DSCR;
    end
  end

  p_single_fault_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_o));

  p_user_ds_prv_ill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_user && at_dp && uses_i == 3'b000) |-> fault_o.ill);
endmodule

// File: rtl/spr_guard_regs.sv
module spr_guard_regs
  import spr_guard_pkg::*;
#(
  parameter int          DATA_W    = 64,
  parameter int          DSCR_W    = 25,
  parameter int          DBG_AW    = 7,
  parameter logic [6:0]  DBG_FEN   = 7'h2e,
  parameter logic [6:0]  DBG_HEN   = 7'h2f
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_we_i,
  input  logic              run_d_i,
  input  logic              dscr_we_i,
  input  logic [DSCR_W-1:0] dscr_d_i,
  input  logic              dbg_valid_i,
  input  logic              dbg_write_i,
  input  logic [DBG_AW-1:0] dbg_addr_i,
  input  logic [HEN_W-1:0]  dbg_wdata_i,
  output logic              run_q_o,
  output logic [DSCR_W-1:0] dscr_q_o,
  output logic [FEN_W-1:0]  fen_q_o,
  output logic [HEN_W-1:0]  hen_q_o,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  logic at_fen, at_hen, dbg_we;

  assign at_fen = (dbg_addr_i == DBG_AW'(DBG_FEN));
  assign at_hen = (dbg_addr_i == DBG_AW'(DBG_HEN));
  assign dbg_we = dbg_valid_i & dbg_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q_o  <= 1'b0;
      dscr_q_o <= '0;
      fen_q_o  <= '0;
      hen_q_o  <= '0;
    end else begin
      if (run_we_i)          run_q_o  <= run_d_i;
      if (dscr_we_i)         dscr_q_o <= dscr_d_i;
      if (dbg_we && at_fen)  fen_q_o  <= dbg_wdata_i[FEN_W-1:0];
      if (dbg_we && at_hen)  hen_q_o  <= dbg_wdata_i;
    end
  end

  always_comb begin
    dbg_rdata_o = '0;
    if (dbg_valid_i && !dbg_write_i) begin
      if (at_fen)      dbg_rdata_o = DATA_W'(fen_q_o);
      else if (at_hen) dbg_rdata_o = DATA_W'(hen_q_o);
    end
  end

  p_dbg_fen_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_i && dbg_write_i && at_fen) |=> fen_q_o == $past(dbg_wdata_i[FEN_W-1:0]));

  p_dbg_other_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_i && dbg_write_i && !at_fen && !at_hen) |=> $stable(fen_q_o) && $stable(hen_q_o));
endmodule

// File: rtl/spr_guard.sv
module spr_guard
  import spr_guard_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int SPR_W      = 10,
  parameter int DSCR_W     = 25,
  parameter int DBG_AW     = 7,
  parameter int RUN_MIRROR = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [SPR_W-1:0]  req_spr_i,
  input  logic [1:0]        req_mode_i,
  input  logic [2:0]        req_uses_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hit_o,
  output logic              fac_unavail_o,
  output logic              hfac_unavail_o,
  output logic              illegal_o,
  input  logic              dbg_valid_i,
  input  logic              dbg_write_i,
  input  logic [DBG_AW-1:0] dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  output logic              run_o
);
  rsel_e             rsel;
  fault_t            fault;
  logic              run_we, dscr_we, run_q;
  logic [DSCR_W-1:0] dscr_q;
  logic [FEN_W-1:0]  fen_q;
  logic [HEN_W-1:0]  hen_q;

  spr_guard_decode #(.SPR_W(SPR_W)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .spr_i     (req_spr_i),
    .mode_i    (req_mode_i),
    .uses_i    (req_uses_i),
    .fen_i     (fen_q),
    .hen_i     (hen_q),
    .hit_o     (hit_o),
    .rsel_o    (rsel),
    .run_we_o  (run_we),
    .dscr_we_o (dscr_we),
    .fault_o   (fault)
  );

  spr_guard_regs #(.DATA_W(DATA_W), .DSCR_W(DSCR_W), .DBG_AW(DBG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_we_i    (run_we),
    .run_d_i     (req_wdata_i[0]),
    .dscr_we_i   (dscr_we),
    .dscr_d_i    (req_wdata_i[DSCR_W-1:0]),
    .dbg_valid_i (dbg_valid_i),
    .dbg_write_i (dbg_write_i),
    .dbg_addr_i  (dbg_addr_i),
    .dbg_wdata_i (dbg_wdata_i[HEN_W-1:0]),
    .run_q_o     (run_q),
    .dscr_q_o    (dscr_q),
    .fen_q_o     (fen_q),
    .hen_q_o     (hen_q),
    .dbg_rdata_o (dbg_rdata_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rsel)
      RSEL_RUN: begin
        rd_data_o[0] = run_q;
        if (req_mode_i != MODE_USER) rd_data_o[RUN_MIRROR] = run_q;
      end
      RSEL_DSCR: rd_data_o = DATA_W'(dscr_q);
      default:   rd_data_o = '0;
    endcase
  end

  assign fac_unavail_o  = fault.fac;
  assign hfac_unavail_o = fault.hfac;
  assign illegal_o      = fault.ill;
  assign run_o          = run_q;

  p_run_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_mode_i != 2'd0 && req_spr_i == SPR_W'(152)
     && !fault.hfac && !fault.fac && !fault.ill) |=> run_o == $past(req_wdata_i[0]));

  p_user_run_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_mode_i == 2'd0 && req_spr_i == SPR_W'(136)
     && req_uses_i == 3'b000) |-> rd_data_o == DATA_W'(run_o));

  p_hv_no_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mode_i[1]) |-> !hfac_unavail_o && !fac_unavail_o);

  p_blocked_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (fault.hfac || fault.fac || fault.ill)) |=> $stable(run_o) && $stable(dscr_q));
endmodule

// File: tb/spr_guard_bench.sv
module spr_guard_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic        wr;
    logic [9:0]  spr;
    logic [63:0] wd;
    logic [63:0] exp_rd;
    logic [2:0]  exp_f;   // {hfac, fac, ill}
    logic        exp_hit;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b1, 10'd152, 64'd1,              64'd0,         3'b000, 1'b1}, // R2 hv set run
    '{2'd0, 1'b0, 10'd136, 64'd0,              64'd1,         3'b000, 1'b1}, // R3 user read
    '{2'd1, 1'b0, 10'd136, 64'd0,              64'h8001,      3'b000, 1'b1}, // R3 sup mirrored
    '{2'd2, 1'b0, 10'd136, 64'd0,              64'h8001,      3'b000, 1'b1}, // R3 hv mirrored
    '{2'd2, 1'b1, 10'd136, 64'd0,              64'd0,         3'b000, 1'b1}, // R4 priv write 136 no-op
    '{2'd0, 1'b0, 10'd136, 64'd0,              64'd1,         3'b000, 1'b1}, // R4 run unchanged
    '{2'd0, 1'b0, 10'd152, 64'd0,              64'd0,         3'b001, 1'b1}, // R4 user read 152 illegal
    '{2'd1, 1'b0, 10'd152, 64'd0,              64'd0,         3'b000, 1'b1}, // R4 priv read 152 no-op
    '{2'd0, 1'b1, 10'd152, 64'd0,              64'd0,         3'b001, 1'b1}, // R4 user write 152 illegal
    '{2'd0, 1'b0, 10'd136, 64'd0,              64'd1,         3'b000, 1'b1}, // R11 blocked write kept run
    '{2'd0, 1'b1, 10'd3,   64'hFFFF_FFFF_FFFF_FFFF, 64'd0,    3'b000, 1'b1}, // R5 user write 3
    '{2'd1, 1'b0, 10'd17,  64'd0,              64'h1FF_FFFF,  3'b000, 1'b1}, // R5 25 bits kept
    '{2'd2, 1'b1, 10'd17,  64'h0ABC_DEF,       64'd0,         3'b000, 1'b1}, // R5 hv write 17
    '{2'd0, 1'b0, 10'd3,   64'd0,              64'h0ABC_DEF,  3'b000, 1'b1}, // R5 user read 3
    '{2'd0, 1'b0, 10'd17,  64'd0,              64'd0,         3'b001, 1'b1}, // R6 user at 17 illegal
    '{2'd1, 1'b1, 10'd152, 64'd0,              64'd0,         3'b000, 1'b1}, // R2 sup clear run
    '{2'd0, 1'b0, 10'd136, 64'd0,              64'd0,         3'b000, 1'b1}, // R2 run now 0
    '{2'd0, 1'b0, 10'd1,   64'd5,              64'd0,         3'b000, 1'b0}  // R12 unowned number
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_spr = '0;
  logic [1:0]  req_mode = '0;
  logic [2:0]  req_uses = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data, dbg_rdata;
  logic        hit, fac, hfac, ill, run;
  logic        dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [6:0]  dbg_addr = '0;
  logic [63:0] dbg_wdata = '0;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  spr_guard u_spr_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_spr_i(req_spr),
    .req_mode_i(req_mode), .req_uses_i(req_uses), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .hit_o(hit), .fac_unavail_o(fac),
    .hfac_unavail_o(hfac), .illegal_o(ill),
    .dbg_valid_i(dbg_valid), .dbg_write_i(dbg_write), .dbg_addr_i(dbg_addr),
    .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata), .run_o(run)
  );

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // result packed as {hit, hfac, fac, ill, rdata}
  task automatic spr_op(input logic [1:0] m, input logic w, input logic [9:0] s,
                        input logic [63:0] d, input logic [2:0] u,
                        input logic [63:0] exp_rd, input logic [2:0] exp_f,
                        input logic exp_hit, input string tag);
    @(negedge clk);
    dbg_valid = 1'b0;
    req_valid = 1'b1; req_write = w; req_spr = s; req_mode = m;
    req_uses = u; req_wdata = d;
    #1;
    check(tag, {hit, hfac, fac, ill, rd_data}, {exp_hit, exp_f, exp_rd});
  endtask

  task automatic dbg_wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_write = 1'b0;
  endtask

  task automatic dbg_rd(input logic [6:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    dbg_valid = 1'b1; dbg_write = 1'b0; dbg_addr = a;
    #1;
    check(tag, {4'd0, dbg_rdata}, {4'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 run_o after reset", {67'd0, run}, 68'd0);
    dbg_rd(7'h2e, 64'd0, "R1 ordinary enable reset");
    dbg_rd(7'h2f, 64'd0, "R1 hypervisor enable reset");
    spr_op(2'd2, 1'b0, 10'd3, 64'd0, 3'b000, 64'd0, 3'b000, 1'b1, "R1 R8 dscr reset, hv ungated");
    spr_op(2'd0, 1'b0, 10'd3, 64'd0, 3'b000, 64'd0, 3'b100, 1'b1, "R6 user at 3, hv enable clear");

    dbg_wr(7'h2e, 64'hFFFF_FFFF_FFFF_FFFF);
    dbg_rd(7'h2e, 64'h7, "R10 ordinary enable width");
    dbg_wr(7'h2f, 64'hF);
    dbg_rd(7'h2f, 64'hF, "R10 hypervisor enable");
    dbg_wr(7'h30, 64'h5);
    dbg_rd(7'h30, 64'd0, "R10 unmapped address reads 0");
    dbg_rd(7'h2e, 64'h7, "R10 unmapped write stored nothing");

    for (int i = 0; i < NV; i++) begin
      spr_op(VEC[i].mode, VEC[i].wr, VEC[i].spr, VEC[i].wd, 3'b000,
             VEC[i].exp_rd, VEC[i].exp_f, VEC[i].exp_hit,
             $sformatf("table row %0d", i));
    end
    spr_op(2'd0, 1'b1, 10'd136, 64'd1, 3'b000, 64'd0, 3'b001, 1'b1, "R4 user write 136 illegal");
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R2 R11 run_o after table", {67'd0, run}, 68'd0);

    // hypervisor data-stream bit cleared
    dbg_wr(7'h2f, 64'hB);
    spr_op(2'd0, 1'b0, 10'd3,  64'd0, 3'b000, 64'd0, 3'b100, 1'b1, "R6 user at 3 hfac");
    spr_op(2'd1, 1'b0, 10'd17, 64'd0, 3'b000, 64'd0, 3'b100, 1'b1, "R7 sup at 17 hfac");
    spr_op(2'd1, 1'b1, 10'd3,  64'h123, 3'b000, 64'd0, 3'b100, 1'b1, "R7 sup write 3 hfac");
    spr_op(2'd2, 1'b0, 10'd17, 64'd0, 3'b000, 64'h0ABC_DEF, 3'b000, 1'b1, "R8 R11 hv read kept value");

    // ordinary data-stream bit cleared
    dbg_wr(7'h2f, 64'hF);
    dbg_wr(7'h2e, 64'h3);
    spr_op(2'd0, 1'b0, 10'd3, 64'd0, 3'b000, 64'd0, 3'b010, 1'b1, "R6 user at 3 fac");
    spr_op(2'd0, 1'b1, 10'd3, 64'h777, 3'b000, 64'd0, 3'b010, 1'b1, "R11 user write blocked");
    spr_op(2'd1, 1'b0, 10'd3, 64'd0, 3'b000, 64'h0ABC_DEF, 3'b000, 1'b1, "R7 R11 sup ignores ordinary enable");

    // facility mask probes on an unowned number
    dbg_wr(7'h2e, 64'h5);
    spr_op(2'd0, 1'b0, 10'd0, 64'd0, 3'b010, 64'd0, 3'b010, 1'b0, "R9 user tar fac");
    spr_op(2'd1, 1'b0, 10'd0, 64'd0, 3'b010, 64'd0, 3'b000, 1'b0, "R9 sup tar allowed");
    spr_op(2'd0, 1'b0, 10'd0, 64'd0, 3'b001, 64'd0, 3'b000, 1'b0, "R9 user prefix allowed");
    dbg_wr(7'h2f, 64'h7);
    spr_op(2'd1, 1'b0, 10'd0, 64'd0, 3'b100, 64'd0, 3'b100, 1'b0, "R9 sup fp hfac");
    spr_op(2'd0, 1'b0, 10'd0, 64'd0, 3'b110, 64'd0, 3'b100, 1'b0, "R9 R11 hfac wins over fac");
    spr_op(2'd3, 1'b0, 10'd0, 64'd0, 3'b111, 64'd0, 3'b000, 1'b0, "R8 R9 hv fp ungated");

    @(negedge clk);
    req_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule